// File: doc/BRIEF.md
# Buzzer Tone Generator with Pin Muxing

This block makes a square-wave buzzer tone and places it on one port pin, or on two port pins carrying the tone and its inverse. The tone starts from a source tick stream. A static option picks that stream. It is either a strobe that marks each period of an internal RC clock, or a local prescaler that fires once every four system clock cycles. Each source tick advances a free-running divider. A static ratio code then picks one divider bit as the tone, which gives a 50% duty cycle at the source rate divided by a power of two, from 2^2 down to 2^9.

Port data bit 0 switches the buzzer on and off. The buzzer values are registered only on source ticks, so a change of that bit takes effect at the next tick and leaves no runt pulse. Each pin has a direction bit (1 = input). Setting it releases the pad's output enable at once, so a buzzer pin becomes a plain input while the buzzer option stays selected. Each pad gives back a registered sample of its input. There is no streaming data path here, so every pin is plain control or status with no valid/ready handshake and no back-pressure. All configuration pins are expected to change only while reset is held.

Top module: `buzzer_tone_port`

## Requirements
- R1: While reset is asserted and after it is released, the prescaler, the divider and both buzzer registers are zero, so both buzzer pin values read 0 until the first source tick.
- R2: With `cfg_src_rc`=1, the divider advances at every rising clock edge where `rc_tick` is 1. With `cfg_src_rc`=0, it advances once every 4 clock cycles, first at the 4th rising edge after reset release.
- R3: Let n be the number of source ticks since reset (modulo 512). At that tick, the pin 0 buzzer register loads `port_data[0]` AND bit (`cfg_ratio`+1) of n. The tone frequency is therefore the source rate / 2^(`cfg_ratio`+2) at a 50% duty cycle. With the system source and `cfg_ratio`=r, the period of `pad_out[0]` is 4*2^(r+2) clock cycles.
- R4: With `cfg_pair`=1, `pad_out[1]` is registered at the same tick as `port_data[0]` AND NOT(tone bit), so both pins are never high together.
- R5: When `port_data[0]` is 0 at a source tick, both buzzer pin values are 0 after that tick.
- R6: With `cfg_pair`=1, `port_data[1]` has no effect on `pad_out` or `pad_oe`.
- R7: With `cfg_pair`=0, pin 1 is a plain I/O pin: `pad_out[1]` equals `port_data[1]` combinationally.
- R8: For each pin, `pad_oe[i]` equals NOT `port_dir[i]` (1 = input releases the pad) in every mode, and `port_rd[i]` is `pad_in[i]` registered one clock earlier, whatever the direction.
- R9: The buzzer register values change only at clock edges where a source tick is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_src_rc | input | 1 | Source select: 1 = RC tick strobe, 0 = system clock / 4 |
| cfg_ratio | input | 3 | Ratio code r: tone = source / 2^(r+2) |
| cfg_pair | input | 1 | 1 = complementary pair on pins 0/1, 0 = pin 0 only |
| rc_tick | input | 1 | One-cycle strobe per internal RC clock period |
| port_dir | input | 2 | Per-pin direction, 1 = input |
| port_data | input | 2 | Port data bits; bit 0 is the buzzer on/off |
| pad_in | input | 2 | Value seen at the pads |
| pad_out | output | 2 | Value driven to the pads |
| pad_oe | output | 2 | Pad output enables |
| port_rd | output | 2 | Registered pad input samples |

## Verification
The bench uses the default parameters: a prescale of 4, a 9-bit divider and eight ratio codes starting at 2^2. With these, a full divider wrap of 512 ticks fits inside each random phase on the RC source, and the slowest tone period of 2048 cycles can be measured directly. Random phases cover both sources, both pin modes and several ratio codes, with each configuration set under reset. Directed cases measure the fastest and slowest periods and check that the on/off bit holds both pins low while data bit 1 is ignored.

// File: rtl/buzz_pkg.sv
package buzz_pkg;
  typedef enum logic {
    SRC_SYSDIV = 1'b0,
    SRC_RC     = 1'b1
  } buzz_src_e;

  typedef enum logic {
    PINS_SINGLE = 1'b0,
    PINS_PAIR   = 1'b1
  } buzz_pins_e;
endpackage

// File: rtl/buzz_tick_src.sv
module buzz_tick_src #(
  parameter int PRESCALE = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  buzz_pkg::buzz_src_e src_sel,
  input  logic rc_tick,
  output logic tick
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

  logic [PW-1:0] pre_q;
  logic          pre_wrap;

  assign pre_wrap = (pre_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pre_q <= '0;
    else if (pre_wrap) pre_q <= '0;
    else               pre_q <= pre_q + 1'b1;
  end

  assign tick = (src_sel == buzz_pkg::SRC_RC) ? rc_tick : pre_wrap;
endmodule

// File: rtl/buzz_divider.sv
module buzz_divider #(
  parameter int MIN_EXP    = 2,
  parameter int NUM_RATIOS = 8,
  parameter int SEL_W      = 3,
  parameter int CNT_W      = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [SEL_W-1:0] ratio,
  output logic             tone_next
);
  localparam int NSLOT = 1 << SEL_W;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic [NSLOT-1:0] taps;

  assign cnt_nxt = cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= cnt_nxt;
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_tap
    if (g < NUM_RATIOS) begin : g_real
      assign taps[g] = cnt_nxt[MIN_EXP - 1 + g];
    end else begin : g_clamp
      assign taps[g] = cnt_nxt[MIN_EXP - 2 + NUM_RATIOS];
    end
  end

  assign tone_next = taps[ratio];
endmodule

// File: rtl/buzz_pin_mux.sv
module buzz_pin_mux (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       tone_next,
  input  buzz_pkg::buzz_pins_e pin_mode,
  input  logic [1:0] port_dir,
  input  logic [1:0] port_data,
  input  logic [1:0] pad_in,
  output logic [1:0] pad_out,
  output logic [1:0] pad_oe,
  output logic [1:0] port_rd
);
  logic buz_tone_q;
  logic buz_inv_q;
  logic [1:0] rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buz_tone_q <= 1'b0;
      buz_inv_q  <= 1'b0;
    end else if (tick) begin
      buz_tone_q <= port_data[0] & tone_next;
      buz_inv_q  <= port_data[0] & ~tone_next;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= pad_in;
  end

  always_comb begin
    pad_out[0] = buz_tone_q;
    pad_out[1] = (pin_mode == buzz_pkg::PINS_PAIR) ? buz_inv_q : port_data[1];
  end

  assign pad_oe  = ~port_dir;
  assign port_rd = rd_q;
endmodule

// File: rtl/buzzer_tone_port.sv
module buzzer_tone_port #(
  parameter int PRESCALE   = 4,
  parameter int MIN_EXP    = 2,
  parameter int NUM_RATIOS = 8,
  localparam int SEL_W     = (NUM_RATIOS > 1) ? $clog2(NUM_RATIOS) : 1,
  localparam int CNT_W     = MIN_EXP + NUM_RATIOS - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_src_rc,
  input  logic [SEL_W-1:0] cfg_ratio,
  input  logic             cfg_pair,
  input  logic             rc_tick,
  input  logic [1:0]       port_dir,
  input  logic [1:0]       port_data,
  input  logic [1:0]       pad_in,
  output logic [1:0]       pad_out,
  output logic [1:0]       pad_oe,
  output logic [1:0]       port_rd
);
  logic src_tick;
  logic tone_next;
  buzz_pkg::buzz_src_e  src_sel;
  buzz_pkg::buzz_pins_e pin_mode;

  assign src_sel  = buzz_pkg::buzz_src_e'(cfg_src_rc);
  assign pin_mode = buzz_pkg::buzz_pins_e'(cfg_pair);

  buzz_tick_src #(.PRESCALE(PRESCALE)) i_tick (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel),
    .rc_tick(rc_tick), .tick(src_tick)
  );

  buzz_divider #(
    .MIN_EXP(MIN_EXP), .NUM_RATIOS(NUM_RATIOS), .SEL_W(SEL_W), .CNT_W(CNT_W)
  ) i_div (
    .clk(clk), .rst_n(rst_n), .tick(src_tick),
    .ratio(cfg_ratio), .tone_next(tone_next)
  );

  buzz_pin_mux i_mux (
    .clk(clk), .rst_n(rst_n), .tick(src_tick), .tone_next(tone_next),
    .pin_mode(pin_mode), .port_dir(port_dir), .port_data(port_data),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .port_rd(port_rd)
  );
endmodule

// File: rtl/buzz_chk.sv
module buzz_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       src_tick,
  input logic       cfg_pair,
  input logic [1:0] port_dir,
  input logic [1:0] port_data,
  input logic [1:0] pad_in,
  input logic [1:0] pad_out,
  input logic [1:0] pad_oe,
  input logic [1:0] port_rd
);
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !src_tick |=> $stable(pad_out[0])); // R9

  AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (src_tick && !port_data[0]) |=> (pad_out[0] == 1'b0)); // R5

  AST_PAIR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_pair |-> !(pad_out[0] && pad_out[1])); // R4

  AST_INPUT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    port_dir[0] |-> !pad_oe[0]); // R8

  AST_SAMPLE_IN: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (port_rd == $past(pad_in))); // R8

  AST_SINGLE_IO: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_pair |-> (pad_out[1] == port_data[1])); // R7
endmodule

bind buzzer_tone_port buzz_chk i_buzz_chk (
  .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .cfg_pair(cfg_pair),
  .port_dir(port_dir), .port_data(port_data), .pad_in(pad_in),
  .pad_out(pad_out), .pad_oe(pad_oe), .port_rd(port_rd)
);

// File: tb/test_buzzer_tone_port.sv
`timescale 1ns/1ps
module test_buzzer_tone_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_src_rc = 1'b0;
  logic [2:0] cfg_ratio = 3'd0;
  logic       cfg_pair = 1'b0;
  logic       rc_tick = 1'b0;
  logic [1:0] port_dir = 2'b00;
  logic [1:0] port_data = 2'b00;
  logic [1:0] pad_in = 2'b00;
  logic [1:0] pad_out, pad_oe, port_rd;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  buzzer_tone_port i_buzzer_tone_port (
    .clk(clk), .rst_n(rst_n), .cfg_src_rc(cfg_src_rc), .cfg_ratio(cfg_ratio),
    .cfg_pair(cfg_pair), .rc_tick(rc_tick), .port_dir(port_dir),
    .port_data(port_data), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .port_rd(port_rd)
  );

  // reference model built from the requirements
  int       m_pre;
  bit [8:0] m_n;
  bit       m_b0, m_b1;
  bit [1:0] m_rd;

  always @(posedge clk) begin
    bit tk;
    bit t;
    if (!rst_n) begin
      m_pre = 0; m_n = '0; m_b0 = 1'b0; m_b1 = 1'b0; m_rd = '0;
    end else begin
      tk = cfg_src_rc ? rc_tick : (m_pre == 3);
      m_pre = (m_pre + 1) % 4;
      if (tk) begin
        m_n  = m_n + 1'b1;
        t    = m_n[cfg_ratio + 1];
        m_b0 = port_data[0] & t;
        m_b1 = port_data[0] & ~t;
      end
      m_rd = pad_in;
    end
  end

  function automatic logic [1:0] exp_out();
    return {cfg_pair ? m_b1 : port_data[1], m_b0};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check(pad_out === exp_out(), cfg_pair ? "R3/R4/R6" : "R3/R7", pad_out, exp_out());
    check(pad_oe === ~port_dir, "R8 oe", pad_oe, ~port_dir);
    check(port_rd === m_rd, "R8 rd", port_rd, m_rd);
  endtask

  task automatic do_reset(input bit src, input logic [2:0] r, input bit pair);
    @(negedge clk);
    rst_n = 1'b0;
    cfg_src_rc = src; cfg_ratio = r; cfg_pair = pair;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic random_phase(input bit src, input logic [2:0] r, input bit pair,
                              input int cycles);
    do_reset(src, r, pair);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      compare_all();
      if ($urandom % 16 == 0) port_data = 2'($urandom);
      if ($urandom % 32 == 0) port_dir  = 2'($urandom);
      pad_in  = 2'($urandom);
      rc_tick = ($urandom % 2 == 0);
    end
  endtask

  task automatic measure_period(input logic [2:0] r);
    int t_first, t_second, cyc;
    bit prev;
    do_reset(1'b0, r, 1'b0);
    port_data = 2'b01; port_dir = 2'b00;
    t_first = -1; t_second = -1; cyc = 0; prev = 1'b0;
    while (t_second < 0 && cyc < 6000) begin
      @(negedge clk);
      cyc++;
      if (pad_out[0] && !prev) begin
        if (t_first < 0) t_first = cyc; else t_second = cyc;
      end
      prev = pad_out[0];
    end
    check((t_second - t_first) == (16 << r), "R2/R3 period",
          t_second - t_first, 16 << r);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset state
    port_data = 2'b01;
    do_reset(1'b0, 3'd0, 1'b1);
    check(pad_out === 2'b00, "R1 reset", pad_out, 2'b00);
    @(negedge clk);
    check(pad_out === 2'b00, "R1 before first tick", pad_out, 2'b00);
    @(negedge clk);
    check(pad_out === 2'b00, "R2 no tick before 4th edge", pad_out, 2'b00);
    repeat (2) @(negedge clk);
    check(pad_out === 2'b10, "R2 first sys tick (pair)", pad_out, 2'b10);

    // R3 fastest and slowest periods
    measure_period(3'd0);
    measure_period(3'd7);

    // R5 / R6: off bit holds both pins low, data bit 1 ignored in pair mode
    do_reset(1'b0, 3'd0, 1'b1);
    port_data = 2'b00; port_dir = 2'b00;
    repeat (10) @(negedge clk);
    check(pad_out === 2'b00, "R5 off low", pad_out, 2'b00);
    port_data = 2'b10;
    repeat (10) @(negedge clk);
    check(pad_out === 2'b00, "R6 data1 ignored", pad_out, 2'b00);
    port_dir = 2'b11;
    @(negedge clk);
    check(pad_oe === 2'b00, "R8 input release", pad_oe, 2'b00);
    port_dir = 2'b00;

    // R7 single mode follows data bit 1
    do_reset(1'b0, 3'd1, 1'b0);
    port_data = 2'b10;
    @(negedge clk);
    check(pad_out[1] === 1'b1, "R7 plain io", pad_out[1], 1'b1);

    // random phases, checked against the model (R2..R9)
    random_phase(1'b1, 3'd0, 1'b1, 1500);
    random_phase(1'b1, 3'd7, 1'b0, 1500);
    random_phase(1'b0, 3'd2, 1'b1, 1500);
    random_phase(1'b0, 3'd5, 1'b0, 1500);
    random_phase(1'b1, 3'd3, 1'b1, 1500);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule